// File: doc/BRIEF.md
# Windowed Expanded-Memory Address Translator

This block sits between a 20-bit real-mode address bus and a memory system that is much larger than 1 MB. A fixed 64 KB window high in the address map is cut into four 16 KB slots. Each slot holds a page number that points at one 16 KB page of a large paged memory of up to 32 MB. An access that lands in an enabled slot is redirected to that page. Any other address reaches base memory unchanged.

Software programs the slots through four consecutive I/O ports, one per slot. Each port holds an enable bit and an 11-bit page number, and a read of a port returns what is stored there. The translation itself is combinational, and its result is captured in output registers, so the result appears one clock after the address is presented.

Top module: `ems_window_xlate`

## Requirements
- R1: After reset all four slots are disabled and every I/O read of a slot port returns 0.
- R2: An I/O write whose port address equals IO_BASE+k (k = 0..3) loads slot k with wdata[15] as the enable bit and wdata[10:0] as the page number. Other wdata bits are not stored.
- R3: An I/O read of port IO_BASE+k returns {enable, 4'b0, page} of slot k on rdata in the same cycle. rd_hit is high only when the port matches.
- R4: Writes or reads to ports outside IO_BASE..IO_BASE+3 change no slot and give rd_hit low with rdata 0.
- R5: An address inside the window (addr[19:16] == WIN_BASE[19:16]) selects slot addr[15:14], with addr[13:0] as the page offset.
- R6: A window access to an enabled slot produces, one cycle later, ems_sel=1, base_sel=0, unmapped=0 and ems_addr={page, addr[13:0]} (25 bits).
- R7: A window access to a disabled slot produces, one cycle later, unmapped=1 with ems_sel=0 and base_sel=0.
- R8: An address outside the window produces, one cycle later, base_sel=1, ems_sel=0, unmapped=0 and base_addr equal to the input address.
- R9: Exactly one of base_sel, ems_sel and unmapped is high in every cycle after the first clock following reset.
- R10: A slot write takes effect for translations presented on the following cycle. The registered output for an address presented in the same cycle as the write uses the old slot value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 20 | Processor real-mode address |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data for a matching port |
| io_rd_hit | output | 1 | Port address matches a slot register |
| base_sel | output | 1 | Registered: base memory selected |
| base_addr | output | 20 | Registered base-memory address |
| ems_sel | output | 1 | Registered: expanded memory selected |
| ems_addr | output | 25 | Registered expanded-memory address |
| unmapped | output | 1 | Registered: window slot disabled |

## Verification
Each of the four slots is given a different page, including page 0 and the top page 2047, so that a slot-select or a page-bit error shows up as a wrong ems_addr. Addresses at the window edges (D0000h, DFFFFh, CFFFFh, E0000h) tell apart a correct window compare from one that is off by one. The offsets used are all-zeros, all-ones and mixed patterns. A slot is disabled again after it has been enabled, which separates the unmapped path from the mapped path. Writes to neighbouring ports show that stray ports are ignored. A write issued in the same cycle as a lookup shows the one-cycle ordering.

// File: rtl/ems_window_xlate.sv
module ems_window_xlate #(
  parameter int AW       = 20,
  parameter int PW       = 11,
  parameter int OFFW     = 14,
  parameter int NSLOT    = 4,
  parameter logic [AW-1:0] WIN_BASE = 20'hD0000,
  parameter logic [15:0]   IO_BASE  = 16'h0208
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [15:0]      io_addr,
  input  logic             io_wr,
  input  logic [15:0]      io_wdata,
  output logic [15:0]      io_rdata,
  output logic             io_rd_hit,
  output logic             base_sel,
  output logic [AW-1:0]    base_addr,
  output logic             ems_sel,
  output logic [PW+OFFW-1:0] ems_addr,
  output logic             unmapped
);
  localparam int SW  = $clog2(NSLOT);
  localparam int WHI = OFFW + SW;
  localparam int EW  = PW + OFFW;

  logic [PW-1:0]    page [NSLOT];
  logic [NSLOT-1:0] en;

  logic [15:0]   port_off;
  logic          port_hit;
  logic [SW-1:0] port_idx;

  assign port_off  = io_addr - IO_BASE;
  assign port_hit  = (io_addr >= IO_BASE) && (port_off < 16'(NSLOT));
  assign port_idx  = port_off[SW-1:0];
  assign io_rd_hit = port_hit;
  assign io_rdata  = port_hit ? {en[port_idx], 15'(page[port_idx])} : 16'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0;
      for (int i = 0; i < NSLOT; i++) page[i] <= '0;
    end else if (io_wr && port_hit) begin
      en[port_idx]   <= io_wdata[15];
      page[port_idx] <= io_wdata[PW-1:0];
    end
  end

  logic          in_win;
  logic [SW-1:0] slot;
  assign in_win = (addr[AW-1:WHI] == WIN_BASE[AW-1:WHI]);
  assign slot   = addr[WHI-1:OFFW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_sel  <= 1'b0;
      ems_sel   <= 1'b0;
      unmapped  <= 1'b0;
      base_addr <= '0;
      ems_addr  <= '0;
    end else begin
      base_sel  <= !in_win;
      ems_sel   <= in_win && en[slot];
      unmapped  <= in_win && !en[slot];
      base_addr <= addr;
      ems_addr  <= {page[slot], addr[OFFW-1:0]};
    end
  end

  logic started;
  always_ff @(posedge clk) started <= rst_n;

  p_onehot_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> $countones({base_sel, ems_sel, unmapped}) == 1);

  p_base_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[AW-1:WHI] != WIN_BASE[AW-1:WHI]) |=> (base_sel && base_addr == $past(addr)));

  p_offset_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ems_sel |-> ems_addr[OFFW-1:0] == base_addr[OFFW-1:0]);

  p_stray_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_rd_hit) |=> ($stable(en)));

  p_no_hit_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd_hit |-> io_rdata == 16'h0);

  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> !ems_sel && !base_sel);
endmodule

// File: tb/ems_window_xlate_test.sv
module ems_window_xlate_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [19:0] addr = 0;
  logic [15:0] io_addr = 0, io_wdata = 0;
  logic io_wr = 0;
  logic [15:0] io_rdata;
  logic io_rd_hit, base_sel, ems_sel, unmapped;
  logic [19:0] base_addr;
  logic [24:0] ems_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ems_window_xlate uut (.clk, .rst_n, .addr, .io_addr, .io_wr, .io_wdata,
    .io_rdata, .io_rd_hit, .base_sel, .base_addr, .ems_sel, .ems_addr, .unmapped);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] p, logic [15:0] d);
    @(negedge clk); io_addr = p; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic io_read(logic [15:0] p, string req, logic hit, logic [15:0] exp);
    @(negedge clk); io_addr = p; #1;
    chk(req, io_rd_hit, hit);
    chk(req, io_rdata, exp);
  endtask

  task automatic lookup(logic [19:0] a, logic b, logic e, logic u, logic [24:0] ea, string req);
    @(negedge clk); addr = a;
    @(negedge clk);
    chk(req, {base_sel, ems_sel, unmapped}, {b, e, u});
    if (b) chk(req, base_addr, a);
    if (e) chk(req, ems_addr, ea);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 4; k++) io_read(16'h0208 + 16'(k), "R1", 1, 16'h0);
    lookup(20'hD4000, 0, 0, 1, 0, "R1");
  endtask

  task automatic t_program;
    io_write(16'h0208, 16'h8000);
    io_write(16'h0209, 16'h8555);
    io_write(16'h020A, 16'hFAAA);
    io_write(16'h020B, 16'h87FF);
    io_read(16'h0208, "R3", 1, 16'h8000);
    io_read(16'h0209, "R3", 1, 16'h8555);
    io_read(16'h020A, "R2", 1, 16'h82AA);
    io_read(16'h020B, "R3", 1, 16'h87FF);
  endtask

  task automatic t_map;
    lookup(20'hD0000, 0, 1, 0, {11'h000, 14'h0000}, "R6 slot0");
    lookup(20'hD7FFF, 0, 1, 0, {11'h555, 14'h3FFF}, "R5 slot1");
    lookup(20'hDA5A5, 0, 1, 0, {11'h2AA, 14'h25A5}, "R5 slot2");
    lookup(20'hDFFFF, 0, 1, 0, {11'h7FF, 14'h3FFF}, "R6 slot3");
  endtask

  task automatic t_base;
    lookup(20'hCFFFF, 1, 0, 0, 0, "R8 below");
    lookup(20'hE0000, 1, 0, 0, 0, "R8 above");
    lookup(20'h01234, 1, 0, 0, 0, "R8 low");
  endtask

  task automatic t_stray;
    io_write(16'h0207, 16'h0000);
    io_write(16'h020C, 16'h0000);
    io_read(16'h0207, "R4", 0, 16'h0);
    io_read(16'h020C, "R4", 0, 16'h0);
    io_read(16'h0208, "R4", 1, 16'h8000);
    io_read(16'h020B, "R4", 1, 16'h87FF);
  endtask

  task automatic t_disable;
    io_write(16'h0209, 16'h0555);
    lookup(20'hD4000, 0, 0, 1, 0, "R7");
    io_read(16'h0209, "R7", 1, 16'h0555);
  endtask

  task automatic t_order;
    @(negedge clk); addr = 20'hD8010; io_addr = 16'h020A; io_wdata = 16'h8123; io_wr = 1;
    @(negedge clk); io_wr = 0;
    chk("R10 old", ems_addr, {11'h2AA, 14'h0010});
    @(negedge clk);
    chk("R10 new", ems_addr, {11'h123, 14'h0010});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_program; t_map; t_base; t_stray; t_disable; t_order;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule